// File: doc/BRIEF.md
# ATA Host Strobe Timing Generator

This block produces the active-low read and write strobes that a parallel ATA host drives during programmed I/O and multiword DMA transfers. It holds one 32-bit timing word for each device on the channel. Each word carries two independent sets of strobe timing. One set is for data-port transfers and the other is for task-file register accesses. Each set has an active length, a recovery length and a one-time setup length.

A request names the device, says whether it is a data transfer or a task-file access, gives the direction and gives a burst length. When the block accepts a request, it latches the chosen device's timing word. It then waits out the setup interval once. After that it alternates active and recovery phases for the requested number of cycles, pulsing a done flag as each active phase ends. It holds busy high for the whole burst. A data request aimed at a device whose word has the Ultra DMA enable set is refused with a one-clock error pulse, because that transfer style is not produced here.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, busy, done and error are low, and both timing words hold 0x01FF_FFFF. With that word a data or task-file burst uses an 8-clock setup, 16 active clocks and 16 recovery clocks.
- R2: In a data request the strobe stays low for word[7:4]+1 clocks and then high for word[3:0]+1 clocks in every cycle.
- R3: In a task-file request the strobe stays low for word[15:12]+1 clocks and then high for word[11:8]+1 clocks in every cycle.
- R4: Before the first active phase of a burst only, the block waits word[21:19]+1 clocks for a data request or word[24:22]+1 clocks for a task-file request, with both strobes high and busy high.
- R5: The word used is the one for req_dev. A clock with cfg_we high loads cfg_word into the word of device cfg_dev.
- R6: The word is captured at the clock that accepts the request. A write to that device's word during the burst changes only later requests.
- R7: A request is accepted at a clock edge where req_valid is high and busy is low. A burst of N cycles gives exactly N active phases. cyc_done is high during the last clock of each active phase. busy is high from the clock after acceptance until the final recovery phase has ended.
- R8: req_write=0 drives only rd_n low and req_write=1 drives only wr_n low. The two strobes are never low together.
- R9: A data request whose word has bit 28 set gives req_err high for exactly the one clock after acceptance, with no busy and no strobe. A task-file request ignores bit 28.
- R10: Word bits 29, 30 and 31 have no effect on strobe timing.
- R11: A request with req_len of 0 is ignored: no busy, no error and no strobe follow.
- R12: req_valid while busy is ignored. The running burst is unchanged and no burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_dev | input | 1 | Device whose word is written |
| cfg_word | input | 32 | New timing word |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_dev | input | 1 | Target device |
| req_taskfile | input | 1 | 1 = task-file access, 0 = data transfer |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_len | input | 8 | Number of strobe cycles in the burst |
| busy | output | 1 | Burst in progress |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cyc_done | output | 1 | High in the last clock of each active phase |
| req_err | output | 1 | One-clock refusal pulse for an Ultra DMA data request |

## Verification
The checker assumes that reset is held for at least one clock before any property is judged. It also assumes the request inputs are ordinary two-state values, so the direction latched at acceptance fixes which strobe may fall. The bench drives requests for exactly one clock while the block is idle. Stray requests are issued only in clocks where busy is already high, so every accepted request is one the bench's arithmetic model expects. Timing words are written only at known points: before a request, or a fixed number of clocks into a burst.

// File: rtl/ata_strb_pkg.sv
package ata_strb_pkg;

   localparam int unsigned TW_W        = 32;
   localparam int unsigned DAT_REC_LSB = 0;
   localparam int unsigned DAT_ACT_LSB = 4;
   localparam int unsigned TF_REC_LSB  = 8;
   localparam int unsigned TF_ACT_LSB  = 12;
   localparam int unsigned DAT_SU_LSB  = 19;
   localparam int unsigned TF_SU_LSB   = 22;
   localparam int unsigned UDMA_BIT    = 28;
   localparam int unsigned PH_W        = 4;
   localparam int unsigned SU_W        = 3;

   localparam logic [TW_W-1:0] TW_SAFE = TW_W'((1 << 25) - 1);

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_ACT   = 2'd2,
      PH_REC   = 2'd3
   } phase_e;

   typedef struct packed {
      logic [PH_W-1:0] act;
      logic [PH_W-1:0] rec;
      logic [SU_W-1:0] setup;
   } tim_s;

   function automatic tim_s pick_timing(input logic [TW_W-1:0] w, input logic tf);
      tim_s t;
      if (tf) begin
         t.act   = w[TF_ACT_LSB +: PH_W];
         t.rec   = w[TF_REC_LSB +: PH_W];
         t.setup = w[TF_SU_LSB  +: SU_W];
      end else begin
         t.act   = w[DAT_ACT_LSB +: PH_W];
         t.rec   = w[DAT_REC_LSB +: PH_W];
         t.setup = w[DAT_SU_LSB  +: SU_W];
      end
      return t;
   endfunction

endpackage

// File: rtl/ata_tw_regs.sv
module ata_tw_regs
   import ata_strb_pkg::*;
#(
   parameter int unsigned DEVS  = 2,
   parameter int unsigned DEV_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DEV_W-1:0]  wr_dev,
   input  logic [TW_W-1:0]   wr_word,
   input  logic [DEV_W-1:0]  rd_dev,
   output logic [TW_W-1:0]   rd_word
);

   logic [TW_W-1:0] words [DEVS];

   for (genvar d = 0; d < DEVS; d++) begin : g_dev
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words[d] <= TW_SAFE;
         end else if (wr_en && (wr_dev == DEV_W'(d))) begin
            words[d] <= wr_word;
         end
      end
   end

   always_comb begin
      rd_word = TW_SAFE;
      for (int i = 0; i < DEVS; i++) begin
         if (rd_dev == DEV_W'(i)) rd_word = words[i];
      end
   end

endmodule

// File: rtl/ata_req_admit.sv
module ata_req_admit
   import ata_strb_pkg::*;
#(
   parameter int unsigned LEN_W = 8
) (
   input  logic              req_valid,
   input  logic              idle,
   input  logic              req_taskfile,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [TW_W-1:0]   word,
   output logic              start,
   output logic              reject,
   output tim_s              tim
);

   logic take;

   always_comb begin
      take   = req_valid && idle && (req_len != '0);
      reject = take && !req_taskfile && word[UDMA_BIT];
      start  = take && !reject;
      tim    = pick_timing(word, req_taskfile);
   end

endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
   import ata_strb_pkg::*;
#(
   parameter int unsigned LEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  tim_s              tim_in,
   input  logic              write_in,
   input  logic [LEN_W-1:0]  len_in,
   output logic              busy,
   output logic              active,
   output logic              last_act,
   output logic              dir_wr
);

   phase_e           phase;
   logic [PH_W-1:0]  cnt;
   logic [LEN_W-1:0] left;
   tim_s             tim_q;
   logic             wr_q;
   logic             cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         left  <= '0;
         tim_q <= '0;
         wr_q  <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_SETUP;
                  cnt   <= PH_W'(tim_in.setup);
                  left  <= len_in;
                  tim_q <= tim_in;
                  wr_q  <= write_in;
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  phase <= PH_ACT;
                  cnt   <= tim_q.act;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_ACT: begin
               if (cnt_zero) begin
                  phase <= PH_REC;
                  cnt   <= tim_q.rec;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_REC: begin
               if (!cnt_zero) begin
                  cnt <= cnt - 1'b1;
               end else if (left == LEN_W'(1)) begin
                  phase <= PH_IDLE;
                  left  <= '0;
               end else begin
                  phase <= PH_ACT;
                  cnt   <= tim_q.act;
                  left  <= left - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (phase != PH_IDLE);
   assign active   = (phase == PH_ACT);
   assign last_act = active && cnt_zero;
   assign dir_wr   = wr_q;

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
   import ata_strb_pkg::*;
#(
   parameter int unsigned DEVS  = 2,
   parameter int unsigned LEN_W = 8,
   localparam int unsigned DEV_W = (DEVS > 1) ? $clog2(DEVS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [DEV_W-1:0] cfg_dev,
   input  logic [TW_W-1:0]  cfg_word,
   input  logic             req_valid,
   input  logic [DEV_W-1:0] req_dev,
   input  logic             req_taskfile,
   input  logic             req_write,
   input  logic [LEN_W-1:0] req_len,
   output logic             busy,
   output logic             rd_n,
   output logic             wr_n,
   output logic             cyc_done,
   output logic             req_err
);

   if (DEVS < 2) begin : g_bad_devs
      $error("ata_strobe_gen: DEVS must be at least 2");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("ata_strobe_gen: LEN_W must be 1..16");
   end

   logic [TW_W-1:0] sel_word;
   logic            start;
   logic            reject;
   tim_s            tim;
   logic            active;
   logic            last_act;
   logic            dir_wr;
   logic            err_q;

   ata_tw_regs #(.DEVS(DEVS), .DEV_W(DEV_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_dev  (cfg_dev),
      .wr_word (cfg_word),
      .rd_dev  (req_dev),
      .rd_word (sel_word)
   );

   ata_req_admit #(.LEN_W(LEN_W)) u_admit (
      .req_valid    (req_valid),
      .idle         (!busy),
      .req_taskfile (req_taskfile),
      .req_len      (req_len),
      .word         (sel_word),
      .start        (start),
      .reject       (reject),
      .tim          (tim)
   );

   ata_phase_seq #(.LEN_W(LEN_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tim_in   (tim),
      .write_in (req_write),
      .len_in   (req_len),
      .busy     (busy),
      .active   (active),
      .last_act (last_act),
      .dir_wr   (dir_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= reject;
   end

   assign rd_n     = !(active && !dir_wr);
   assign wr_n     = !(active &&  dir_wr);
   assign cyc_done = last_act;
   assign req_err  = err_q;

endmodule

// File: rtl/ata_strobe_gen_chk.sv
module ata_strobe_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic rd_n,
   input logic wr_n,
   input logic cyc_done,
   input logic req_err
);

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n || wr_n));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_n && wr_n && !cyc_done));

   assert_done_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> (!rd_n || !wr_n));

   assert_done_then_rec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> (rd_n && wr_n));

   assert_err_no_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (!busy && rd_n && wr_n));

   assert_end_after_rec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(rd_n && wr_n));

endmodule

bind ata_strobe_gen ata_strobe_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .cyc_done (cyc_done),
   .req_err  (req_err)
);

// File: tb/sim_ata_strobe_gen.sv
module sim_ata_strobe_gen;

   localparam int CLK_P = 10;
   localparam int LEN_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [0:0]       cfg_dev = '0;
   logic [31:0]      cfg_word = '0;
   logic             req_valid = 1'b0;
   logic [0:0]       req_dev = '0;
   logic             req_taskfile = 1'b0;
   logic             req_write = 1'b0;
   logic [LEN_W-1:0] req_len = '0;
   logic             busy, rd_n, wr_n, cyc_done, req_err;

   int          n_run = 0;
   int          n_fail = 0;
   bit          ended = 1'b0;
   logic [31:0] mw [2];

   always #(CLK_P/2) clk = ~clk;

   ata_strobe_gen #(.DEVS(2), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
      .cfg_word(cfg_word), .req_valid(req_valid), .req_dev(req_dev),
      .req_taskfile(req_taskfile), .req_write(req_write), .req_len(req_len),
      .busy(busy), .rd_n(rd_n), .wr_n(wr_n), .cyc_done(cyc_done),
      .req_err(req_err)
   );

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   task automatic cfg_write(input int dev, input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_dev = 1'(dev); cfg_word = w;
      @(negedge clk);
      cfg_we = 1'b0;
      mw[dev] = w;
   endtask

   // One request, compared clock by clock against an arithmetic model.
   // stray: extra request while busy (R12). midw: rewrite this device's word at k==1 (R6).
   task automatic run(input string tag, input int dev, input bit tf, input bit wr,
                      input int len, input bit stray, input bit midw,
                      input logic [31:0] neww);
      logic [31:0] w;
      int s, a, r, per, total, j, p;
      bit rej, bad;
      bit e_busy, e_rd, e_wr, e_done, e_err, act;
      w   = mw[dev];
      s   = tf ? int'(w[24:22]) : int'(w[21:19]);
      a   = tf ? int'(w[15:12]) : int'(w[7:4]);
      r   = tf ? int'(w[11:8])  : int'(w[3:0]);
      per = a + r + 2;
      rej = (len != 0) && !tf && w[28];
      total = (len == 0 || rej) ? 0 : s + 1 + len * per;
      bad = 1'b0;
      n_run++;
      @(negedge clk);
      req_valid = 1'b1; req_dev = 1'(dev); req_taskfile = tf;
      req_write = wr; req_len = LEN_W'(len);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < total + 4; k++) begin
         e_busy = (k < total);
         act = 1'b0; e_done = 1'b0;
         if (e_busy && k >= s + 1) begin
            j = k - s - 1;
            p = j % per;
            act = (p < a + 1);
            e_done = (p == a);
         end
         e_rd  = !(act && !wr);
         e_wr  = !(act && wr);
         e_err = (k == 0) && rej;
         if (!bad && (busy !== e_busy || rd_n !== e_rd || wr_n !== e_wr ||
                      cyc_done !== e_done || req_err !== e_err)) begin
            bad = 1'b1;
            n_fail++;
            $display("FAIL %s clk %0d: busy/rd_n/wr_n/done/err act=%b%b%b%b%b exp=%b%b%b%b%b",
                     tag, k, busy, rd_n, wr_n, cyc_done, req_err,
                     e_busy, e_rd, e_wr, e_done, e_err);
         end
         if (stray && k == 1 && total > 3) begin
            req_valid = 1'b1; req_dev = 1'(1 - dev); req_taskfile = !tf;
            req_write = !wr; req_len = LEN_W'(2);
         end else begin
            req_valid = 1'b0;
         end
         if (midw && k == 1) begin
            cfg_we = 1'b1; cfg_dev = 1'(dev); cfg_word = neww;
         end else begin
            cfg_we = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      cfg_we = 1'b0;
      if (midw) mw[dev] = neww;
   endtask

   function automatic logic [31:0] mkword(input int su_d, input int act_d, input int rec_d,
                                          input int su_t, input int act_t, input int rec_t);
      logic [31:0] w;
      w = '0;
      w[3:0]   = 4'(rec_d);
      w[7:4]   = 4'(act_d);
      w[11:8]  = 4'(rec_t);
      w[15:12] = 4'(act_t);
      w[21:19] = 3'(su_d);
      w[24:22] = 3'(su_t);
      return w;
   endfunction

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not end, act=timeout exp=finish");
      finish_up();
   end

   initial begin
      mw[0] = 32'h01FF_FFFF;
      mw[1] = 32'h01FF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state at the ports
      n_run++;
      if (busy !== 1'b0 || rd_n !== 1'b1 || wr_n !== 1'b1 || cyc_done !== 1'b0 || req_err !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset outputs act=%b%b%b%b%b exp=01100", busy, rd_n, wr_n, cyc_done, req_err);
      end
      // R1: default words give slowest timing on both devices
      run("R1 default data dev1", 1, 1'b0, 1'b0, 1, 1'b0, 1'b0, '0);
      run("R1 default taskfile dev0", 0, 1'b1, 1'b1, 1, 1'b0, 1'b0, '0);

      // R2 R3 R4 R5 R7 R8: sweep devices, access kind, direction and length
      for (int d = 0; d < 2; d++) begin
         for (int tf = 0; tf < 2; tf++) begin
            for (int wr = 0; wr < 2; wr++) begin
               for (int len = 1; len <= 3; len++) begin
                  cfg_write(0, mkword(len % 3, (len + wr) % 4, (tf + 1) % 3,
                                      (len + 1) % 4, (wr + 2) % 4, len % 2));
                  cfg_write(1, mkword((len + 2) % 4, (tf + 2) % 3, (len + wr) % 3,
                                      wr + 1, (len + 1) % 3, (tf + len) % 4));
                  run("R2 R3 R4 R5 R7 R8 sweep", d, 1'(tf), 1'(wr), len, 1'b0, 1'b0, '0);
               end
            end
         end
      end

      // R2 R3: zero fields, one-clock phases
      cfg_write(0, 32'h0000_0000);
      run("R2 zero fields data", 0, 1'b0, 1'b1, 4, 1'b0, 1'b0, '0);
      run("R3 zero fields taskfile", 0, 1'b1, 1'b0, 4, 1'b0, 1'b0, '0);

      // R6: rewrite during burst only affects later request
      cfg_write(1, mkword(2, 3, 1, 1, 2, 2));
      run("R6 word held during burst", 1, 1'b0, 1'b0, 3, 1'b0, 1'b1, mkword(0, 0, 5, 3, 0, 0));
      run("R6 new word on next request", 1, 1'b0, 1'b0, 2, 1'b0, 1'b0, '0);

      // R9: Ultra DMA bit refuses data, not task-file
      cfg_write(0, mkword(1, 2, 1, 2, 1, 3) | 32'h1000_0000);
      run("R9 data refused read", 0, 1'b0, 1'b0, 2, 1'b0, 1'b0, '0);
      run("R9 data refused write", 0, 1'b0, 1'b1, 1, 1'b0, 1'b0, '0);
      run("R9 taskfile unaffected", 0, 1'b1, 1'b1, 2, 1'b0, 1'b0, '0);

      // R10: mode bits 29..31 have no effect
      cfg_write(1, mkword(3, 1, 2, 0, 2, 1) | 32'hE000_0000);
      run("R10 mode bits data", 1, 1'b0, 1'b1, 3, 1'b0, 1'b0, '0);
      run("R10 mode bits taskfile", 1, 1'b1, 1'b0, 2, 1'b0, 1'b0, '0);

      // R11: zero length ignored
      run("R11 zero length data", 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, '0);
      run("R11 zero length refused-word", 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, '0);

      // R12: request while busy ignored
      run("R12 stray while busy", 1, 1'b0, 1'b0, 2, 1'b1, 1'b0, '0);
      run("R12 stray while busy tf", 0, 1'b1, 1'b1, 3, 1'b1, 1'b0, '0);

      finish_up();
   end

endmodule